// File: doc/BRIEF.md
# Ferroelectric Memory Power and Sleep Sequencer

This block sits beside the bus controller of a parallel ferroelectric memory and owns the two power-related controls of that memory: the active-low sleep line, and a force that keeps chip enable high. It brings the memory from power-good to the first permitted access. It moves the memory into sleep and back out on request from the host. It blocks all accesses while the memory is not ready for them. The bus controller starts a read or write only while `access_ok` is high. It must also keep chip enable high whenever `ce_force` is asserted.

Every wait is a parameterised count of clock cycles. These waits are the hold window after power becomes good, the shortest time the sleep line may stay low, and the hold window after sleep ends. Sleep is granted only between accesses, when the bus controller reports idle and the precharge of the last access has finished. A wake request that arrives too early is remembered and serviced when the minimum sleep time runs out. When power-good drops, the block withdraws access in the same cycle, so chip enable is already high before the supply falls.

Top module: `fram_pwr_seq`

## Requirements
- R1: While and right after reset, `sleep_n` = 1, `ce_force` = 1 and `access_ok` = 0.
- R2: The first clock edge that samples `pwr_good` high starts a power-up window. `access_ok` stays 0 and `ce_force` stays 1 for PWRUP_HOLD_CYC edges after that edge. `access_ok` becomes 1 at the following edge.
- R3: When `pwr_good` is 0, `ce_force` = 1 and `access_ok` = 0 in the same cycle, without waiting for a clock edge. From the next edge `sleep_n` = 1. When power returns, the full power-up window of R2 is run again.
- R4: While access is allowed, an edge that samples `sleep_req`, `bus_idle` and `precharge_done` all at 1 drives `sleep_n` to 0 and `access_ok` to 0 after that edge.
- R5: A `sleep_req` sampled while `bus_idle` = 0 or `precharge_done` = 0 has no effect: `sleep_n` and `access_ok` both stay 1.
- R6: After sleep entry, `sleep_n` stays 0 for exactly SLEEP_MIN_CYC cycles when a wake request was seen during that time. Such an early wake request is held, and `sleep_n` returns to 1 at the edge that ends the minimum time.
- R7: With no early wake request, `sleep_n` stays 0 until an edge samples `wake_req` = 1, and returns to 1 right after that edge.
- R8: After `sleep_n` returns to 1, `ce_force` stays 1 and `access_ok` stays 0 for WAKE_HOLD_CYC edges after the wake edge. `access_ok` becomes 1 at the following edge.
- R9: `wake_req` has no effect while access is allowed. `sleep_req` has no effect during a hold window.
- R10: `access_ok` = 1 only while `sleep_n` = 1 and `ce_force` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Supply is within range |
| sleep_req | input | 1 | Host asks for sleep |
| wake_req | input | 1 | Host asks to leave sleep |
| bus_idle | input | 1 | Bus controller has no access in progress |
| precharge_done | input | 1 | Precharge of the last access has finished |
| sleep_n | output | 1 | Active-low sleep line to the memory |
| ce_force | output | 1 | Bus controller must hold chip enable high |
| access_ok | output | 1 | Bus controller may start accesses |

## Verification
Two events can meet in one cycle during the minimum sleep time: the timer running out and a wake request that has to be honoured. The bench pulses `wake_req` one cycle after sleep entry and then counts negedges. It expects `sleep_n` to stay low through the last cycle of the minimum time and to rise exactly at the edge that ends it, with the hold window starting at that same edge. A second case keeps wake away until well past the minimum time, to show that sleep persists without a request. Loss of power while asleep is also checked, to confirm that it overrides the sleep state within a single cycle.

// File: rtl/fram_pwr_seq.sv
module fram_pwr_seq #(
  parameter int PWRUP_HOLD_CYC = 45000,
  parameter int SLEEP_MIN_CYC  = 100,
  parameter int WAKE_HOLD_CYC  = 45000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic sleep_req,
  input  logic wake_req,
  input  logic bus_idle,
  input  logic precharge_done,
  output logic sleep_n,
  output logic ce_force,
  output logic access_ok
);

  localparam int MAX_A  = (PWRUP_HOLD_CYC > WAKE_HOLD_CYC) ? PWRUP_HOLD_CYC : WAKE_HOLD_CYC;
  localparam int MAX_C  = (MAX_A > SLEEP_MIN_CYC) ? MAX_A : SLEEP_MIN_CYC;
  localparam int CW     = $clog2(MAX_C + 1);
  localparam int MIN_HOLD = (PWRUP_HOLD_CYC < WAKE_HOLD_CYC) ? PWRUP_HOLD_CYC : WAKE_HOLD_CYC;
  localparam logic [CW-1:0] LD_PUP  = CW'(PWRUP_HOLD_CYC - 1);
  localparam logic [CW-1:0] LD_SMIN = CW'(SLEEP_MIN_CYC - 1);
  localparam logic [CW-1:0] LD_WAKE = CW'(WAKE_HOLD_CYC - 1);

  typedef enum logic [2:0] {
    ST_OFF, ST_PUP, ST_RDY, ST_SMIN, ST_SLP, ST_WAKE
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          wake_pend;
  logic          cnt_done;
  logic          go_sleep;

  assign cnt_done = (cnt == '0);
  assign go_sleep = sleep_req & bus_idle & precharge_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_OFF;
      cnt       <= '0;
      wake_pend <= 1'b0;
    end else if (!pwr_good) begin
      st        <= ST_OFF;
      wake_pend <= 1'b0;
    end else begin
      case (st)
        ST_OFF: begin
          st  <= ST_PUP;
          cnt <= LD_PUP;
        end
        ST_PUP: begin
          if (cnt_done) st <= ST_RDY;
          else          cnt <= cnt - 1'b1;
        end
        ST_RDY: begin
          if (go_sleep) begin
            st        <= ST_SMIN;
            cnt       <= LD_SMIN;
            wake_pend <= 1'b0;
          end
        end
        ST_SMIN: begin
          if (wake_req) wake_pend <= 1'b1;
          if (cnt_done) begin
            if (wake_pend | wake_req) begin
              st  <= ST_WAKE;
              cnt <= LD_WAKE;
            end else begin
              st <= ST_SLP;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_SLP: begin
          if (wake_req) begin
            st  <= ST_WAKE;
            cnt <= LD_WAKE;
          end
        end
        ST_WAKE: begin
          if (cnt_done) st <= ST_RDY;
          else          cnt <= cnt - 1'b1;
        end
        default: st <= ST_OFF;
      endcase
    end
  end

  assign sleep_n   = !((st == ST_SMIN) || (st == ST_SLP));
  assign access_ok = pwr_good && (st == ST_RDY);
  assign ce_force  = !access_ok;

  logic [31:0] low_run;
  logic [31:0] ce_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run <= '0;
      ce_run  <= '0;
    end else begin
      low_run <= sleep_n  ? 32'd0 : low_run + 32'd1;
      ce_run  <= ce_force ? ce_run + 32'd1 : 32'd0;
    end
  end

  a_r10_access_awake: assert property (@(posedge clk) disable iff (!rst_n)
    access_ok |-> (sleep_n && !ce_force));

  a_r5_sleep_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_n) |-> $past(sleep_req && bus_idle && precharge_done));

  a_r6_min_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && pwr_good && low_run != 0) |-> (low_run >= SLEEP_MIN_CYC));

  a_r8_hold_before_access: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_ok) |-> (ce_run >= MIN_HOLD));

  a_r3_power_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_ok) |-> $past(pwr_good));

endmodule

// File: tb/test_fram_pwr_seq.sv
module test_fram_pwr_seq;
  localparam int P = 20;
  localparam int M = 6;
  localparam int K = 15;

  logic clk = 1'b0;
  logic rst_n, pwr_good, sleep_req, wake_req, bus_idle, precharge_done;
  logic sleep_n, ce_force, access_ok;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fram_pwr_seq #(.PWRUP_HOLD_CYC(P), .SLEEP_MIN_CYC(M), .WAKE_HOLD_CYC(K)) i_fram_pwr_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sleep_req(sleep_req),
    .wake_req(wake_req), .bus_idle(bus_idle), .precharge_done(precharge_done),
    .sleep_n(sleep_n), .ce_force(ce_force), .access_ok(access_ok)
  );

  // {sleep_req, bus_idle, precharge_done, wake_req, exp sleep_n, exp access_ok}
  localparam logic [5:0] VEC [0:5] = '{
    6'b1000_11, 6'b1100_11, 6'b1010_11, 6'b0110_11, 6'b0111_11, 6'b1110_00
  };

  task automatic chk(input string req, input logic [2:0] exp);
    checks++;
    if ({sleep_n, ce_force, access_ok} !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b (sleep_n,ce_force,access_ok) t=%0t",
               req, {sleep_n, ce_force, access_ok}, exp, $time);
    end
  endtask

  task automatic power_up();
    pwr_good = 1'b1;
    repeat (P) @(negedge clk);
    chk("R2", 3'b110);
    @(negedge clk);
    chk("R2", 3'b101);
  endtask

  initial begin
    rst_n = 0; pwr_good = 0; sleep_req = 0; wake_req = 0; bus_idle = 0; precharge_done = 0;
    repeat (3) @(negedge clk);
    chk("R1", 3'b110);
    rst_n = 1;
    @(negedge clk);
    chk("R1", 3'b110);
    chk("R3", 3'b110);

    power_up();

    // R5 gating, R9 wake ignored when ready, R4 final entry
    for (int v = 0; v < 6; v++) begin
      {sleep_req, bus_idle, precharge_done, wake_req} = VEC[v][5:2];
      @(negedge clk);
      checks++;
      if ({sleep_n, access_ok} !== VEC[v][1:0]) begin
        fails++;
        $display("FAIL R5/R4/R9 vec=%0d act=%b exp=%b", v, {sleep_n, access_ok}, VEC[v][1:0]);
      end
    end
    sleep_req = 0; wake_req = 0;

    // R6 early wake held until the minimum time ends
    wake_req = 1;
    @(negedge clk);
    wake_req = 0;
    chk("R6", 3'b010);
    repeat (M - 2) @(negedge clk);
    chk("R6", 3'b010);
    @(negedge clk);
    chk("R6", 3'b110);
    // R9 sleep request during the wake hold window
    sleep_req = 1;
    @(negedge clk);
    sleep_req = 0;
    chk("R9", 3'b110);
    repeat (K - 2) @(negedge clk);
    chk("R8", 3'b110);
    @(negedge clk);
    chk("R8", 3'b101);

    // R7 sleep persists without a wake request
    sleep_req = 1;
    @(negedge clk);
    sleep_req = 0;
    chk("R4", 3'b010);
    repeat (M + 5) @(negedge clk);
    chk("R7", 3'b010);
    wake_req = 1;
    @(negedge clk);
    wake_req = 0;
    chk("R7", 3'b110);
    repeat (K - 1) @(negedge clk);
    chk("R8", 3'b110);
    @(negedge clk);
    chk("R8", 3'b101);

    // R9 held wake request while ready
    wake_req = 1;
    repeat (3) @(negedge clk);
    wake_req = 0;
    chk("R9", 3'b101);

    // R3 power loss while ready
    pwr_good = 0;
    #1 chk("R3", 3'b110);
    @(negedge clk);
    chk("R3", 3'b110);
    power_up();

    // R3 power loss while asleep
    sleep_req = 1;
    @(negedge clk);
    sleep_req = 0;
    chk("R4", 3'b010);
    pwr_good = 0;
    #1 chk("R3", 3'b010);
    @(negedge clk);
    chk("R3", 3'b110);
    repeat (M + 2) @(negedge clk);
    chk("R3", 3'b110);
    power_up();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule